// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Bank

The block turns one fast bus clock into a set of slow, single-cycle clock-enable strobes. Input filters and other slow logic use these strobes as their time base, so they never need a derived clock. One bank serves every filter channel. Each strobe then sets the integration step of any channel that selects it.

Each stage is a down-counter with its own reload value. A stage steps only in cycles where its enable input is high. When it reaches zero it reloads and raises its strobe for one cycle. A design-time mask decides where each stage takes its enable from: either the base clock directly, or the strobe of the stage below it. A cascaded stage therefore divides by the product of the reloads along its chain. The default mask gives stages 0 and 1 the base clock and chains stages 2 through 7 behind stage 1. Reload values are set while the bank is held in reset and stay constant while it runs.

Top module: `cediv_bank`

## Requirements
- R1: All strobes are low while `rst_ni` is low and in the first clock cycle after reset release. In that first cycle every stage loads its reload value.
- R2: A stage fed by the base clock with reload value R (R ≥ 2) first raises its strobe after the (R+1)-th rising edge following reset release. After that the strobe repeats every R cycles.
- R3: A cascaded stage decrements only on strobes of the stage below it. Its strobe period is therefore the product of the reload values along its chain (stage 2 = R1·R2, stage 7 = R1·R2·…·R7 with the default mask).
- R4: For a reload value other than 1, a strobe is high for exactly one cycle at a time.
- R5: A reload value of 1 makes a stage pass its enable through unchanged. A stage fed by the base clock then strobes in every cycle from the second cycle after reset release.
- R6: A reload value of 0 divides by 2^CNT_W.
- R7: A strobe of a cascaded stage is high only in the cycle right after a strobe of the stage below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | N_STAGES×CNT_W | Reload value per stage, packed stage-major; held constant outside reset |
| ce_o | output | N_STAGES | Clock-enable strobe per stage |

## Verification
The bench builds the bank with CNT_W = 6 and the default eight-stage mask. This narrow width makes a full 2^CNT_W wrap (64 cycles) cheap to reach, so the reload-zero case can be run to several periods. Six stages of small reload factors still multiply to a 1920-cycle period on the top stage, which stays well inside the run length. Three reload sets are applied across separate resets: mixed factors, all-ones and zero reloads. The bench compares all eight strobes against a behavioural event-counting model on every cycle.

// File: rtl/cediv_pkg.sv
package cediv_pkg;
  typedef enum logic {ST_LOAD = 1'b0, ST_RUN = 1'b1} stage_state_e;
endpackage

// File: rtl/cediv_stage.sv
module cediv_stage
  import cediv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  stage_state_e     st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_LOAD;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (st_q == ST_LOAD) begin
        cnt_q <= reload_i - ONE;  // reload 0 wraps to all ones: divide by 2^CNT_W
        st_q  <= ST_RUN;
      end else if (en_i) begin
        if (cnt_q == '0) begin
          cnt_q   <= reload_i - ONE;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  AST_QUIET_UNTIL_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD) |-> !pulse_q); // R1
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && reload_i != '0) |-> (cnt_q < reload_i)); // R2
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(en_i)); // R3
  AST_PULSE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (cnt_q == reload_i - ONE)); // R6
  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && reload_i != ONE) |=> !pulse_q); // R4
endmodule

// File: rtl/cediv_route.sv
module cediv_route #(
  parameter int                    N_STAGES     = 8,
  parameter logic [N_STAGES-1:0]   CASCADE_MASK = '0
) (
  input  logic [N_STAGES-2:0] pulse_i,
  output logic [N_STAGES-1:0] en_o
);
  for (genvar i = 0; i < N_STAGES; i++) begin : g_en
    if (i > 0) begin : g_hi
      if (CASCADE_MASK[i]) begin : g_chain
        assign en_o[i] = pulse_i[i-1];
      end else begin : g_base
        assign en_o[i] = 1'b1;
      end
    end else begin : g_lo
      assign en_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cediv_bank.sv
module cediv_bank #(
  parameter int                  N_STAGES     = 8,
  parameter int                  CNT_W        = 16,
  parameter logic [N_STAGES-1:0] CASCADE_MASK = {{(N_STAGES-2){1'b1}}, 2'b00}
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_STAGES-1:0][CNT_W-1:0] reload_i,
  output logic [N_STAGES-1:0]            ce_o
);
  logic [N_STAGES-1:0] en;

  cediv_route #(
    .N_STAGES    (N_STAGES),
    .CASCADE_MASK(CASCADE_MASK)
  ) u_route (
    .pulse_i(ce_o[N_STAGES-2:0]),
    .en_o   (en)
  );

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    cediv_stage #(.CNT_W(CNT_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[i]),
      .reload_i(reload_i[i]),
      .pulse_o (ce_o[i])
    );
    if (i > 0 && CASCADE_MASK[i]) begin : g_chk
      AST_CASCADE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o[i] |-> $past(ce_o[i-1])); // R7
    end
  end
endmodule

// File: tb/cediv_bank_test.sv
module cediv_bank_test;
  localparam int N = 8;
  localparam int W = 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [N-1:0][W-1:0] reload = '0;
  logic [N-1:0]       ce;

  cediv_bank #(.N_STAGES(N), .CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .ce_o(ce)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit exp_ce[N];
  int ev[N];
  bit loaded;
  int edge_n;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  function automatic int div_of(input int i);
    return (reload[i] == 0) ? (1 << W) : int'(reload[i]);
  endfunction

  // behavioural model: count enabled events since load, strobe on every div-th
  always @(posedge clk) begin
    if (!rst_n) begin
      loaded = 1'b0;
      edge_n = 0;
      for (int i = 0; i < N; i++) begin ev[i] = 0; exp_ce[i] = 1'b0; end
    end else begin
      bit nxt[N];
      edge_n++;
      if (!loaded) begin
        loaded = 1'b1;
        for (int i = 0; i < N; i++) nxt[i] = 1'b0;
      end else begin
        for (int i = 0; i < N; i++) begin
          bit en;
          en = (i < 2) ? 1'b1 : exp_ce[i-1];
          nxt[i] = 1'b0;
          if (en) begin
            ev[i]++;
            nxt[i] = (ev[i] % div_of(i)) == 0;
          end
        end
      end
      for (int i = 0; i < N; i++) exp_ce[i] = nxt[i];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      for (int i = 0; i < N; i++)
        chk(ce[i] == exp_ce[i], (i < 2) ? "R2" : "R3", int'(ce[i]), int'(exp_ce[i]));
  end

  task automatic start(input logic [N-1:0][W-1:0] rl);
    @(negedge clk);
    rst_n  = 1'b0;
    reload = rl;
    repeat (3) @(negedge clk);
    chk(ce == '0, "R1", int'(ce), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce == '0, "R1", int'(ce), 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first0, first1, last2, last7, prev2;
    bit prev0, prev_c2;
    // pattern A: mixed factors, stage 7 period 40*3*2*2*1*2*2 = 1920
    start({6'd2, 6'd2, 6'd1, 6'd2, 6'd2, 6'd3, 6'd40, 6'd8});
    first0 = -1; first1 = -1; last2 = -1; last7 = -1; prev0 = 0; prev_c2 = 0;
    for (int c = 0; c < 4500; c++) begin
      if (ce[0] && first0 < 0) first0 = edge_n;
      if (ce[1] && first1 < 0) first1 = edge_n;
      if (ce[0] && prev0) chk(1'b0, "R4", 2, 1);
      if (ce[3]) chk(prev_c2, "R7", int'(prev_c2), 1);
      if (ce[2]) begin
        if (last2 >= 0) chk(edge_n - last2 == 120, "R3", edge_n - last2, 120);
        last2 = edge_n;
      end
      if (ce[7]) begin
        if (last7 >= 0) chk(edge_n - last7 == 1920, "R3", edge_n - last7, 1920);
        last7 = edge_n;
      end
      prev0 = ce[0];
      prev_c2 = ce[2];
      @(negedge clk);
    end
    chk(first0 == 9, "R2", first0, 9);
    chk(first1 == 41, "R2", first1, 41);
    chk(last7 > 0, "R3", last7, 1);
    // pattern B: reload 1 everywhere, strobes stay high
    start({N{6'd1}});
    prev2 = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (c >= 8 && ce[0]) prev2++;
    end
    chk(prev2 == 52, "R5", prev2, 52);
    chk(ce == '1, "R5", int'(ce), 255);
    // pattern C: reload 0 divides by 64
    start({6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd0, 6'd0});
    first0 = -1; last2 = -1; prev2 = 0;
    for (int c = 0; c < 1500; c++) begin
      if (ce[0]) begin
        if (first0 < 0) first0 = edge_n;
        else chk(edge_n - last2 == 64, "R6", edge_n - last2, 64);
        last2 = edge_n;
        prev2++;
      end
      @(negedge clk);
    end
    chk(first0 == 65, "R6", first0, 65);
    chk(prev2 >= 20, "R6", prev2, 20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule